// File: doc/BRIEF.md
# Dual-Issue In-Order Issue Selector

This block is the issue stage of a two-wide in-order pipeline. It keeps up to two decoded instructions in two slots, the older one in slot 0. Each cycle it decides whether both slots issue, only the older slot issues, or nothing issues. An instruction goes either to the integer unit or to the floating-point unit. The floating-point unit is multi-cycle and not pipelined, and there is one unit of each class. A register scoreboard records the destinations of floating-point operations that are still in flight. An external writeback port clears those entries.

The upstream decoder offers up to two instructions per cycle, in program order. The block accepts them only into slots that are free after the current cycle's issue. Issue results are registered. The decision made in a cycle appears on the issue outputs after that cycle's clock edge, together with copies of the issued instructions. A synchronous flush empties the slots, the scoreboard and the floating-point occupancy in a single cycle.

Top module: `dual_issue_sel`

## Requirements
- R1: Instruction word layout, MSB to LSB: unit class (1 bit, 0 = integer, 1 = floating point), source A enable, source A index (REG_W bits), source B enable, source B index, destination enable, destination index. `iss_vld` bit 0 marks the older slot and bit 1 the younger slot. Its only values are 00, 01 and 11, and it shows the decision of the previous cycle.
- R2: Issue follows program order. While the older slot is held, the younger slot never issues, even if it is free of hazards. A younger instruction left behind moves into the older slot and may issue in the next cycle.
- R3: The two slots do not issue together when the younger has an enabled source equal to the older's enabled destination (read-after-write).
- R4: The two slots do not issue together when both have enabled destinations that are equal (write-after-write).
- R5: The two slots do not issue together when the younger's enabled destination equals an enabled source of the older (write-after-read).
- R6: Two instructions of the same unit class never issue together. After a floating-point instruction issues, the next floating-point instruction can issue no earlier than FP_OCC cycles later. Integer issue is not affected by this.
- R7: When a floating-point instruction with an enabled destination other than 0 issues, that register is marked pending. A writeback (`wb_vld`, `wb_reg`) clears the mark. An instruction whose enabled source or enabled destination is pending does not issue.
- R8: Register index 0 never creates a dependency and is never marked pending.
- R9: `in_rdy[0]` is high when at least one slot is free after this cycle's issue, and `in_rdy[1]` is high when both slots are free. Lane 0 is accepted when `in_vld[0]` and `in_rdy[0]` are both high. Lane 1 is accepted only together with lane 0, and a lane 1 offered alone is dropped. An accepted instruction can issue in the next cycle.
- R10: During a flush cycle nothing issues and `in_rdy` is 00. After the flush edge the slots, the pending marks and the floating-point occupancy are all cleared, so `iss_vld` reads 00.
- R11: After reset `iss_vld` is 00 and `in_rdy` is 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Synchronous clear of slots, scoreboard and occupancy |
| in_vld | input | 2 | Offered-instruction flags, lane 0 older |
| in_op0 | input | INSN_W | Older offered instruction |
| in_op1 | input | INSN_W | Younger offered instruction |
| in_rdy | output | 2 | Free-slot indication after this cycle's issue |
| wb_vld | input | 1 | Floating-point writeback strobe |
| wb_reg | input | REG_W | Register whose pending mark is cleared |
| iss_vld | output | 2 | Registered issue mask, bit 0 older |
| iss_op0 | output | INSN_W | Instruction issued from the older slot |
| iss_op1 | output | INSN_W | Instruction issued from the younger slot |

## Verification
Some properties are checked by assertions on every cycle:
- the 10 mask never appears;
- a registered pair never contains a read-after-write, write-after-write or write-after-read conflict, or two instructions of the same class;
- the slots stay compact;
- register 0 never becomes pending;
- a floating-point start never overlaps unit occupancy;
- a flush silences the next cycle.

Other behaviour only the bench scenarios can show:
- how many cycles a floating-point follower waits;
- that a writeback releases a held instruction in the next decision;
- that `in_rdy` counts the slots freed in the same cycle;
- that a held older instruction keeps a ready younger one back.

// File: rtl/iss_pkg.sv
package iss_pkg;
  localparam int REG_W = 5;
  localparam int NREG  = 1 << REG_W;

  typedef enum logic {UNIT_INT = 1'b0, UNIT_FP = 1'b1} unit_e;

  typedef struct packed {
    unit_e             unit;
    logic              src_a_en;
    logic [REG_W-1:0]  src_a;
    logic              src_b_en;
    logic [REG_W-1:0]  src_b;
    logic              dst_en;
    logic [REG_W-1:0]  dst;
  } insn_t;

  localparam int INSN_W = $bits(insn_t);

  // true when an enabled source of i names register r (r = 0 never counts)
  function automatic logic reads_reg(insn_t i, logic [REG_W-1:0] r);
    return (r != '0) && ((i.src_a_en && (i.src_a == r)) ||
                         (i.src_b_en && (i.src_b == r)));
  endfunction

  // true when i has a real destination (register 0 is discarded)
  function automatic logic has_dst(insn_t i);
    return i.dst_en && (i.dst != '0);
  endfunction
endpackage

// File: rtl/iss_pair_check.sv
// Cross-slot hazard detection between the older and younger instruction.
module iss_pair_check
  import iss_pkg::*;
(
  input  insn_t older,
  input  insn_t younger,
  output logic  raw_hit,
  output logic  waw_hit,
  output logic  war_hit,
  output logic  unit_clash,
  output logic  pair_ok
);
  always_comb begin
    raw_hit    = has_dst(older) && reads_reg(younger, older.dst);
    waw_hit    = has_dst(older) && has_dst(younger) && (older.dst == younger.dst);
    war_hit    = has_dst(younger) && reads_reg(older, younger.dst);
    unit_clash = (older.unit == younger.unit);
    pair_ok    = !(raw_hit || waw_hit || war_hit || unit_clash);
  end
endmodule

// File: rtl/iss_hold_track.sv
// Pending-register scoreboard plus occupancy counter of the multi-cycle FP unit.
module iss_hold_track
  import iss_pkg::*;
#(
  parameter int FP_OCC = 3,
  parameter int NQ     = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             fp_start,
  input  logic             set_en,
  input  logic [REG_W-1:0] set_reg,
  input  logic             wb_vld,
  input  logic [REG_W-1:0] wb_reg,
  input  insn_t            q_op      [NQ],
  output logic             q_blocked [NQ]
);
  localparam int CNT_W = (FP_OCC > 1) ? $clog2(FP_OCC + 1) : 1;

  logic [NREG-1:0]  pend;
  logic [CNT_W-1:0] occ_cnt;
  logic             fp_busy;

  assign fp_busy = (occ_cnt != '0);

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      pend <= '0;
    end else begin
      if (wb_vld && (wb_reg != '0)) pend[wb_reg] <= 1'b0;
      if (set_en && (set_reg != '0)) pend[set_reg] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      occ_cnt <= '0;
    end else if (fp_start) begin
      occ_cnt <= CNT_W'(FP_OCC - 1);
    end else if (occ_cnt != '0) begin
      occ_cnt <= occ_cnt - 1'b1;
    end
  end

  for (genvar q = 0; q < NQ; q++) begin : g_query
    logic src_a_pend, src_b_pend, dst_pend, unit_busy;
    always_comb begin
      src_a_pend   = q_op[q].src_a_en && (q_op[q].src_a != '0) && pend[q_op[q].src_a];
      src_b_pend   = q_op[q].src_b_en && (q_op[q].src_b != '0) && pend[q_op[q].src_b];
      dst_pend     = has_dst(q_op[q]) && pend[q_op[q].dst];
      unit_busy    = (q_op[q].unit == UNIT_FP) && fp_busy;
      q_blocked[q] = src_a_pend || src_b_pend || dst_pend || unit_busy;
    end
  end

  assert_zero_reg_idle_R8: assert property (@(posedge clk) disable iff (rst)
    !pend[0]);

  assert_fp_start_free_R6: assert property (@(posedge clk) disable iff (rst)
    fp_start |-> !fp_busy);

  assert_flush_clears_R10: assert property (@(posedge clk) disable iff (rst)
    flush |=> (pend == '0) && (occ_cnt == '0));
endmodule

// File: rtl/iss_slot_queue.sv
// Two ordered holding slots; refills only the slots freed by this cycle's issue.
module iss_slot_queue
  import iss_pkg::*;
#(
  parameter int NS = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       flush,
  input  logic [1:0] n_issue,
  input  logic [1:0] in_vld,
  input  insn_t      in_op   [NS],
  output logic [1:0] in_rdy,
  output logic [1:0] slot_vld,
  output insn_t      slot_op [NS]
);
  localparam int CW = $clog2(NS + 1);

  logic [1:0]    rem_vld;
  insn_t         rem_op  [NS];
  logic [CW-1:0] rem_cnt;
  logic          take0, take1;
  logic [1:0]    nxt_vld;
  insn_t         nxt_op  [NS];

  // what stays in the slots after this cycle's issue, kept compact
  always_comb begin
    rem_vld   = slot_vld;
    rem_op[0] = slot_op[0];
    rem_op[1] = slot_op[1];
    if (n_issue == 2'd1) begin
      rem_op[0] = slot_op[1];
      rem_vld   = {1'b0, slot_vld[1]};
    end else if (n_issue == 2'd2) begin
      rem_vld = '0;
    end
  end

  assign rem_cnt   = CW'(rem_vld[0]) + CW'(rem_vld[1]);
  assign in_rdy[0] = !flush && (rem_cnt < CW'(NS));
  assign in_rdy[1] = !flush && (rem_cnt == '0);
  assign take0     = in_vld[0] && in_rdy[0];
  assign take1     = in_vld[1] && take0 && in_rdy[1];

  always_comb begin
    nxt_vld   = rem_vld;
    nxt_op[0] = rem_op[0];
    nxt_op[1] = rem_op[1];
    case (rem_cnt)
      CW'(0): begin
        nxt_op[0] = in_op[0];
        nxt_op[1] = in_op[1];
        nxt_vld   = {take1, take0};
      end
      CW'(1): begin
        nxt_op[1] = in_op[0];
        nxt_vld   = {take0, 1'b1};
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      slot_vld <= '0;
    end else begin
      slot_vld <= nxt_vld;
    end
    for (int s = 0; s < NS; s++) slot_op[s] <= nxt_op[s];
  end

  assert_slots_compact_R2: assert property (@(posedge clk) disable iff (rst)
    slot_vld[1] |-> slot_vld[0]);

  assert_issue_within_fill_R2: assert property (@(posedge clk) disable iff (rst)
    n_issue <= 2'($countones(slot_vld)));
endmodule

// File: rtl/dual_issue_sel.sv
module dual_issue_sel
  import iss_pkg::*;
#(
  parameter int FP_OCC = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic [1:0]        in_vld,
  input  logic [INSN_W-1:0] in_op0,
  input  logic [INSN_W-1:0] in_op1,
  output logic [1:0]        in_rdy,
  input  logic              wb_vld,
  input  logic [REG_W-1:0]  wb_reg,
  output logic [1:0]        iss_vld,
  output logic [INSN_W-1:0] iss_op0,
  output logic [INSN_W-1:0] iss_op1
);
  localparam int NSLOT = 2;

  insn_t      in_op    [NSLOT];
  insn_t      slot_op  [NSLOT];
  logic [1:0] slot_vld;
  logic       blocked  [NSLOT];
  logic       raw_hit, waw_hit, war_hit, unit_clash, pair_ok;
  logic       go_old, go_young;
  logic [1:0] n_issue;
  logic       fp_start, fp_set;
  insn_t      fp_op;

  assign in_op[0] = insn_t'(in_op0);
  assign in_op[1] = insn_t'(in_op1);

  iss_slot_queue #(.NS(NSLOT)) u_queue (
    .clk      (clk),
    .rst      (rst),
    .flush    (flush),
    .n_issue  (n_issue),
    .in_vld   (in_vld),
    .in_op    (in_op),
    .in_rdy   (in_rdy),
    .slot_vld (slot_vld),
    .slot_op  (slot_op)
  );

  iss_pair_check u_pair (
    .older      (slot_op[0]),
    .younger    (slot_op[1]),
    .raw_hit    (raw_hit),
    .waw_hit    (waw_hit),
    .war_hit    (war_hit),
    .unit_clash (unit_clash),
    .pair_ok    (pair_ok)
  );

  iss_hold_track #(.FP_OCC(FP_OCC), .NQ(NSLOT)) u_track (
    .clk       (clk),
    .rst       (rst),
    .flush     (flush),
    .fp_start  (fp_start),
    .set_en    (fp_set),
    .set_reg   (fp_op.dst),
    .wb_vld    (wb_vld),
    .wb_reg    (wb_reg),
    .q_op      (slot_op),
    .q_blocked (blocked)
  );

  // in-order selection: the younger slot can only ride along with the older
  assign go_old   = !flush && slot_vld[0] && !blocked[0];
  assign go_young = go_old && slot_vld[1] && !blocked[1] && pair_ok;
  assign n_issue  = 2'(go_old) + 2'(go_young);

  // at most one FP op leaves per cycle because a pair never shares a unit
  always_comb begin
    fp_op    = slot_op[0];
    fp_start = 1'b0;
    if (go_old && (slot_op[0].unit == UNIT_FP)) begin
      fp_start = 1'b1;
    end else if (go_young && (slot_op[1].unit == UNIT_FP)) begin
      fp_op    = slot_op[1];
      fp_start = 1'b1;
    end
    fp_set = fp_start && has_dst(fp_op);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      iss_vld <= '0;
    end else begin
      iss_vld <= {go_young, go_old};
    end
    iss_op0 <= slot_op[0];
    iss_op1 <= slot_op[1];
  end

  insn_t out_old, out_young;
  assign out_old   = insn_t'(iss_op0);
  assign out_young = insn_t'(iss_op1);

  assert_no_lone_young_R1: assert property (@(posedge clk) disable iff (rst)
    iss_vld != 2'b10);

  assert_pair_no_raw_R3: assert property (@(posedge clk) disable iff (rst)
    (iss_vld == 2'b11) |-> !(has_dst(out_old) && reads_reg(out_young, out_old.dst)));

  assert_pair_no_waw_R4: assert property (@(posedge clk) disable iff (rst)
    (iss_vld == 2'b11) |-> !(has_dst(out_old) && has_dst(out_young) &&
                             (out_old.dst == out_young.dst)));

  assert_pair_no_war_R5: assert property (@(posedge clk) disable iff (rst)
    (iss_vld == 2'b11) |-> !(has_dst(out_young) && reads_reg(out_old, out_young.dst)));

  assert_pair_units_differ_R6: assert property (@(posedge clk) disable iff (rst)
    (iss_vld == 2'b11) |-> (out_old.unit != out_young.unit));

  assert_flush_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    flush |=> (iss_vld == 2'b00));
endmodule

// File: tb/test_dual_issue_sel.sv
module test_dual_issue_sel;
  localparam int IW  = iss_pkg::INSN_W;
  localparam int RW  = iss_pkg::REG_W;
  localparam int OCC = 3;
  localparam int NV  = 12;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          flush = 1'b0;
  logic [1:0]    in_vld = '0;
  logic [IW-1:0] in_op0 = '0;
  logic [IW-1:0] in_op1 = '0;
  logic [1:0]    in_rdy;
  logic          wb_vld = 1'b0;
  logic [RW-1:0] wb_reg = '0;
  logic [1:0]    iss_vld;
  logic [IW-1:0] iss_op0;
  logic [IW-1:0] iss_op1;

  int n_chk = 0;
  int n_err = 0;

  always #10 clk = ~clk;

  dual_issue_sel #(.FP_OCC(OCC)) i_dual_issue_sel (
    .clk(clk), .rst(rst), .flush(flush), .in_vld(in_vld),
    .in_op0(in_op0), .in_op1(in_op1), .in_rdy(in_rdy),
    .wb_vld(wb_vld), .wb_reg(wb_reg), .iss_vld(iss_vld),
    .iss_op0(iss_op0), .iss_op1(iss_op1)
  );

  // word layout per R1: unit, srcA en, srcA, srcB en, srcB, dst en, dst
  function automatic logic [IW-1:0] mk(bit fp, bit ae, int a, bit be, int b, bit de, int d);
    logic [RW-1:0] ra, rb, rd;
    ra = a[RW-1:0];
    rb = b[RW-1:0];
    rd = d[RW-1:0];
    return {fp, ae, ra, be, rb, de, rd};
  endfunction

  typedef struct packed {
    logic [IW-1:0] a;
    logic [IW-1:0] b;
    logic [1:0]    mask;
    logic [1:0]    nxt;
    logic [7:0]    req;
  } vec_t;

  localparam vec_t VEC [NV] = '{
    '{mk(0,1,2,1,3,1,1),  mk(1,1,5,1,6,1,4),  2'b11, 2'b00, 8'd6}, // R6 int+fp pair
    '{mk(0,1,2,0,0,1,1),  mk(0,1,3,0,0,1,4),  2'b01, 2'b01, 8'd6}, // R6 int+int, R2 shift
    '{mk(1,1,2,0,0,1,1),  mk(1,1,3,0,0,1,4),  2'b01, 2'b00, 8'd6}, // R6 fp+fp, unit busy
    '{mk(0,1,2,0,0,1,7),  mk(1,1,7,0,0,1,8),  2'b01, 2'b01, 8'd3}, // R3 via source A
    '{mk(0,1,2,0,0,1,7),  mk(1,0,0,1,7,1,8),  2'b01, 2'b01, 8'd3}, // R3 via source B
    '{mk(0,1,2,0,0,1,9),  mk(1,1,3,0,0,1,9),  2'b01, 2'b01, 8'd4}, // R4 same dst
    '{mk(0,1,10,0,0,1,11),mk(1,1,3,0,0,1,10), 2'b01, 2'b01, 8'd5}, // R5 via source A
    '{mk(0,1,0,0,0,1,0),  mk(1,1,0,0,0,1,0),  2'b11, 2'b00, 8'd8}, // R8 register 0
    '{mk(0,1,2,0,0,0,12), mk(1,1,12,0,0,1,3), 2'b11, 2'b00, 8'd3}, // R3 dst disabled
    '{mk(0,1,2,0,0,1,13), mk(1,0,13,0,0,1,3), 2'b11, 2'b00, 8'd3}, // R3 src disabled
    '{mk(1,1,2,0,0,1,15), mk(0,1,3,0,0,1,16), 2'b11, 2'b00, 8'd6}, // R6 fp older, int younger
    '{mk(0,1,2,1,14,1,1), mk(1,1,3,0,0,1,14), 2'b01, 2'b01, 8'd5}  // R5 via source B
  };

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  task automatic do_flush();
    @(negedge clk);
    flush  = 1'b1;
    in_vld = '0;
    @(negedge clk);
    flush = 1'b0;
  endtask

  initial begin
    #(20 * 100000);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [IW-1:0] opa, opb;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R11", "iss_vld after reset", 32'(iss_vld), 32'd0);
    chk("R11", "in_rdy after reset", 32'(in_rdy), 32'd3);

    // table of pair scenarios, each from a clean state
    for (int k = 0; k < NV; k++) begin
      string tag;
      tag = $sformatf("R%0d vec%0d", VEC[k].req, k);
      do_flush();
      in_vld = 2'b11;
      in_op0 = VEC[k].a;
      in_op1 = VEC[k].b;
      @(negedge clk);
      in_vld = '0;
      // R9: freed slots after this decision equal the issue count
      chk("R9", $sformatf("in_rdy vec%0d", k), 32'(in_rdy), 32'(VEC[k].mask));
      @(negedge clk);
      chk(tag, "issue mask", 32'(iss_vld), 32'(VEC[k].mask));
      if (VEC[k].mask[0]) chk(tag, "older op", 32'(iss_op0), 32'(VEC[k].a));
      if (VEC[k].mask[1]) chk(tag, "younger op", 32'(iss_op1), 32'(VEC[k].b));
      @(negedge clk);
      chk("R2", $sformatf("follow-up mask vec%0d", k), 32'(iss_vld), 32'(VEC[k].nxt));
      if (VEC[k].nxt == 2'b01)
        chk("R2", $sformatf("shifted op vec%0d", k), 32'(iss_op0), 32'(VEC[k].b));
    end

    // R6: FP follower waits for unit occupancy
    do_flush();
    opa = mk(1,0,0,0,0,1,26);
    opb = mk(1,0,0,0,0,1,27);
    in_vld = 2'b01; in_op0 = opa;
    @(negedge clk);
    in_op0 = opb;
    @(negedge clk);
    in_vld = '0;
    chk("R6", "first fp issue", 32'(iss_vld), 32'd1);
    chk("R6", "first fp op", 32'(iss_op0), 32'(opa));
    for (int j = 1; j < OCC; j++) begin
      @(negedge clk);
      chk("R6", "fp follower held", 32'(iss_vld), 32'd0);
    end
    @(negedge clk);
    chk("R6", "fp follower issues", 32'(iss_vld), 32'd1);
    chk("R6", "fp follower op", 32'(iss_op0), 32'(opb));

    // R2 / R7 / R9: held older keeps hazard-free younger back until writeback
    do_flush();
    in_vld = 2'b01; in_op0 = mk(1,0,0,0,0,1,22);
    @(negedge clk);
    in_vld = '0;
    repeat (OCC + 1) @(negedge clk);
    opa = mk(0,1,22,0,0,1,23);
    opb = mk(1,1,1,0,0,1,24);
    in_vld = 2'b11; in_op0 = opa; in_op1 = opb;
    @(negedge clk);
    in_vld = '0;
    chk("R9", "both slots held", 32'(in_rdy), 32'd0);
    for (int j = 0; j < 3; j++) begin
      @(negedge clk);
      chk("R2", "younger kept behind held older", 32'(iss_vld), 32'd0);
    end
    wb_vld = 1'b1; wb_reg = RW'(22);
    @(negedge clk);
    wb_vld = 1'b0;
    chk("R7", "still held in writeback cycle", 32'(iss_vld), 32'd0);
    @(negedge clk);
    chk("R7", "pair released after writeback", 32'(iss_vld), 32'd3);
    chk("R7", "released older op", 32'(iss_op0), 32'(opa));
    chk("R7", "released younger op", 32'(iss_op1), 32'(opb));

    // R7 destination pending, R9 one slot, R10 flush clears everything
    do_flush();
    in_vld = 2'b01; in_op0 = mk(1,0,0,0,0,1,25);
    @(negedge clk);
    in_vld = '0;
    repeat (OCC + 1) @(negedge clk);
    in_vld = 2'b01; in_op0 = mk(0,1,3,0,0,1,25);
    @(negedge clk);
    in_vld = '0;
    chk("R9", "one slot held", 32'(in_rdy), 32'd1);
    @(negedge clk);
    chk("R7", "pending destination blocks", 32'(iss_vld), 32'd0);
    flush = 1'b1;
    #1;
    chk("R10", "in_rdy during flush", 32'(in_rdy), 32'd0);
    @(negedge clk);
    flush = 1'b0;
    chk("R10", "no issue after flush", 32'(iss_vld), 32'd0);
    @(negedge clk);
    chk("R10", "flushed slot gone", 32'(iss_vld), 32'd0);
    opa = mk(0,1,25,0,0,1,2);
    in_vld = 2'b01; in_op0 = opa;
    @(negedge clk);
    in_vld = '0;
    @(negedge clk);
    chk("R10", "scoreboard cleared by flush", 32'(iss_vld), 32'd1);
    chk("R10", "post-flush op", 32'(iss_op0), 32'(opa));

    // R9: lane 1 alone is dropped
    do_flush();
    in_vld = 2'b10; in_op1 = mk(0,1,2,0,0,1,3);
    @(negedge clk);
    in_vld = '0;
    @(negedge clk);
    chk("R9", "lone lane1 ignored", 32'(iss_vld), 32'd0);
    @(negedge clk);
    chk("R9", "lone lane1 still ignored", 32'(iss_vld), 32'd0);
    chk("R1", "mask never 10", 32'(iss_vld == 2'b10), 32'd0);

    summary();
  end
endmodule